// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This unit decides, in the cycle a load request arrives, where that load must get its data. It examines every store that is older than the load and has not yet been written to memory, and it searches them from the youngest to the oldest. The result is one of three outcomes. The load can take its bytes from a store, the load can be sent back for replay because a store covers only part of its bytes, or the load can go to the cache. The store-queue contents are presented on flat read ports, and the whole search is done combinationally through a priority select.

Three pieces of state persist between loads. A stall record holds the oldest load that hit a partial overlap, together with the sequence number of the blocking store. The record clears when that store reports completion. A blocked-load record holds the oldest load that was sent to a cache that was blocked at the time. Forwarded data comes out one cycle after the request. An uncacheable load may execute only when it is at the load-queue head and has reached commit. In any other case it is rejected with a fault and sent for replay.

Top module: `stld_fwd_unit`

## Requirements
- R1: The search covers the entries from one slot older than the load's store-queue index back to the writeback pointer inclusive, wrapping modulo the queue depth. The load's own slot is not searched. When the two indices are equal, no entry is searched.
- R2: An entry whose size field is 0 does not take part in the search. Sizes are byte counts of 1, 2, 4 or 8.
- R3: A store forwards when it fully contains the load, meaning load_addr >= store_addr and load_addr+load_size <= store_addr+store_size. Among the stores that decide the search, the youngest one wins. Its data is shifted right by 8*(load_addr AND (store_size-1)) bits, and bytes above the load size are zeroed. fwd_valid and fwd_data appear in the cycle after the request.
- R4: A partial overlap is an intersection of the two byte ranges without full containment. When the store is not completed, replay is raised in the same cycle, and neither mem_go nor a forward follows.
- R5: A partial overlap with a completed store is skipped, and the search continues to older entries.
- R6: A replay caused by partial overlap sets stall, stall_st_seq (the store's sequence number) and stall_ld_idx (the load index) in the next cycle. While stall is set, the record is replaced only by a load with a numerically lower sequence number.
- R7: stall clears in the cycle after st_done_valid is asserted with st_done_seq equal to stall_st_seq. A completion with any other sequence number leaves stall set.
- R8: When ld_uncached is set and either ld_at_head or ld_at_commit is low, fault and replay are raised, mem_go stays low, no forward follows and the stall record is left unchanged.
- R9: When no store decides the search, mem_go is raised in the same cycle.
- R10: When mem_go is raised while dcache_blocked is high, blk_flag and blk_seq record the load in the next cycle. This does not happen if a load with a lower sequence number is already recorded. blk_clear clears blk_flag.
- R11: After reset, fwd_valid, replay, fault, mem_go, stall and blk_flag are all 0.
- R12: While ld_valid is low, replay, fault and mem_go stay low and no forward follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 4 | Load size in bytes |
| ld_seq | input | SEQW | Load age (lower is older) |
| ld_lq_idx | input | LQW | Load-queue index of the load |
| ld_sq_idx | input | SIW | Store-queue index recorded for the load |
| ld_uncached | input | 1 | Load targets uncacheable space |
| ld_at_head | input | 1 | Load is at the load-queue head |
| ld_at_commit | input | 1 | Load has reached commit |
| wb_ptr | input | SIW | Oldest store not yet written back |
| sq_addr | input | SQ_DEPTH*AW | Store addresses, entry i at [i*AW +: AW] |
| sq_size | input | SQ_DEPTH*4 | Store sizes in bytes, 0 = unknown |
| sq_data | input | SQ_DEPTH*DW | Store data |
| sq_done | input | SQ_DEPTH | Store already written back |
| sq_seq | input | SQ_DEPTH*SEQW | Store sequence numbers |
| dcache_blocked | input | 1 | Cache cannot accept a request |
| st_done_valid | input | 1 | A store has completed |
| st_done_seq | input | SEQW | Sequence number of the completed store |
| blk_clear | input | 1 | Clears the blocked-load record |
| fwd_valid | output | 1 | Forwarded data valid |
| fwd_data | output | DW | Forwarded load data |
| replay | output | 1 | Load must be rescheduled |
| fault | output | 1 | Uncacheable load issued too early |
| mem_go | output | 1 | Load proceeds to the cache |
| stall | output | 1 | Partial-overlap stall pending |
| stall_st_seq | output | SEQW | Store that caused the stall |
| stall_ld_idx | output | LQW | Load recorded for the stall |
| blk_flag | output | 1 | A load hit a blocked cache |
| blk_seq | output | SEQW | Sequence number of that load |

## Verification
A fixed store queue is probed with a table of loads. The table varies the start index and the writeback pointer so that the search window is empty, holds one entry, or wraps across the end of the queue. It also places loads at different byte offsets inside a store, which separates correct shift amounts and size masks from wrong ones. A completed store that holds a partial overlap sits above an older store that fully contains the load, which shows whether completed partial overlaps are skipped or wrongly stop the search. Directed sequences then send older and younger loads into the stall and blocked-load records, which shows whether both records keep only the oldest load and whether only the matching completion clears the stall.

// File: rtl/stld_fwd_unit.sv
module stld_fwd_unit #(
  parameter int SQ_DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 64,
  parameter int SEQW = 8,
  parameter int LQW = 3,
  localparam int SIW = $clog2(SQ_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  input  logic [AW-1:0]            ld_addr,
  input  logic [3:0]               ld_size,
  input  logic [SEQW-1:0]          ld_seq,
  input  logic [LQW-1:0]           ld_lq_idx,
  input  logic [SIW-1:0]           ld_sq_idx,
  input  logic                     ld_uncached,
  input  logic                     ld_at_head,
  input  logic                     ld_at_commit,
  input  logic [SIW-1:0]           wb_ptr,
  input  logic [SQ_DEPTH*AW-1:0]   sq_addr,
  input  logic [SQ_DEPTH*4-1:0]    sq_size,
  input  logic [SQ_DEPTH*DW-1:0]   sq_data,
  input  logic [SQ_DEPTH-1:0]      sq_done,
  input  logic [SQ_DEPTH*SEQW-1:0] sq_seq,
  input  logic                     dcache_blocked,
  input  logic                     st_done_valid,
  input  logic [SEQW-1:0]          st_done_seq,
  input  logic                     blk_clear,
  output logic                     fwd_valid,
  output logic [DW-1:0]            fwd_data,
  output logic                     replay,
  output logic                     fault,
  output logic                     mem_go,
  output logic                     stall,
  output logic [SEQW-1:0]          stall_st_seq,
  output logic [LQW-1:0]           stall_ld_idx,
  output logic                     blk_flag,
  output logic [SEQW-1:0]          blk_seq
);

  logic [AW-1:0]   st_addr [SQ_DEPTH];
  logic [3:0]      st_size [SQ_DEPTH];
  logic [DW-1:0]   st_data [SQ_DEPTH];
  logic [SEQW-1:0] st_seq  [SQ_DEPTH];
  logic [SQ_DEPTH-1:0] is_full, is_part;

  logic [AW:0] ld_end;
  assign ld_end = {1'b0, ld_addr} + (AW+1)'(ld_size);

  for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_ent
    logic [AW:0] st_end;
    logic        lo_ok, hi_ok, meets;
    assign st_addr[g] = sq_addr[g*AW +: AW];
    assign st_size[g] = sq_size[g*4 +: 4];
    assign st_data[g] = sq_data[g*DW +: DW];
    assign st_seq[g]  = sq_seq[g*SEQW +: SEQW];
    assign st_end = {1'b0, st_addr[g]} + (AW+1)'(st_size[g]);
    assign lo_ok  = ld_addr >= st_addr[g];
    assign hi_ok  = ld_end <= st_end;
    assign meets  = ({1'b0, ld_addr} < st_end) && (ld_end > {1'b0, st_addr[g]});
    assign is_full[g] = (st_size[g] != 4'd0) && lo_ok && hi_ok;
    assign is_part[g] = (st_size[g] != 4'd0) && meets && !(lo_ok && hi_ok) && !sq_done[g];
  end

  logic           hit_full, hit_part;
  logic [SIW-1:0] hit_idx;

  always_comb begin
    int span;
    int e;
    hit_full = 1'b0;
    hit_part = 1'b0;
    hit_idx  = '0;
    span = (int'(ld_sq_idx) - int'(wb_ptr) + SQ_DEPTH) % SQ_DEPTH;
    for (int k = SQ_DEPTH - 1; k >= 1; k--) begin
      e = (int'(ld_sq_idx) + SQ_DEPTH - k) % SQ_DEPTH;
      if (k <= span && (is_full[e] || is_part[e])) begin
        hit_full = is_full[e];
        hit_part = is_part[e];
        hit_idx  = SIW'(e);
      end
    end
  end

  logic          go;
  assign fault  = ld_valid && ld_uncached && !(ld_at_head && ld_at_commit);
  assign go     = ld_valid && !fault;
  assign replay = fault || (go && hit_part);
  assign mem_go = go && !hit_full && !hit_part;

  logic [2:0]    shamt;
  logic [DW-1:0] ld_mask, shifted;
  assign shamt   = ld_addr[2:0] & (st_size[hit_idx][2:0] - 3'd1);
  assign shifted = st_data[hit_idx] >> {shamt, 3'b000};

  always_comb begin
    for (int j = 0; j < DW / 8; j++)
      ld_mask[j*8 +: 8] = (j < int'(ld_size)) ? 8'hFF : 8'h00;
  end

  logic [SEQW-1:0] stall_ld_seq;
  logic            stall_take, blk_take;
  assign stall_take = go && hit_part && (!stall || ld_seq < stall_ld_seq);
  assign blk_take   = mem_go && dcache_blocked && !(blk_flag && blk_seq < ld_seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid    <= 1'b0;
      fwd_data     <= '0;
      stall        <= 1'b0;
      stall_st_seq <= '0;
      stall_ld_idx <= '0;
      stall_ld_seq <= '0;
      blk_flag     <= 1'b0;
      blk_seq      <= '0;
    end else begin
      fwd_valid <= go && hit_full;
      if (go && hit_full) fwd_data <= shifted & ld_mask;
      if (stall_take) begin
        stall        <= 1'b1;
        stall_st_seq <= st_seq[hit_idx];
        stall_ld_idx <= ld_lq_idx;
        stall_ld_seq <= ld_seq;
      end else if (st_done_valid && st_done_seq == stall_st_seq) begin
        stall <= 1'b0;
      end
      if (blk_take) begin
        blk_flag <= 1'b1;
        blk_seq  <= ld_seq;
      end else if (blk_clear) begin
        blk_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/stld_fwd_unit_chk.sv
module stld_fwd_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_valid,
  input logic fault,
  input logic replay,
  input logic mem_go,
  input logic fwd_valid,
  input logic stall,
  input logic blk_flag,
  input logic dcache_blocked
);

  // R3
  fwd_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(ld_valid && !replay && !mem_go));

  // R4
  replay_not_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> !mem_go);

  // R8
  fault_replays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> replay);

  // R6
  stall_from_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(replay && !fault));

  // R10
  blk_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_flag) |-> $past(mem_go && dcache_blocked));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !(replay || mem_go || fault));

endmodule

bind stld_fwd_unit stld_fwd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .fault(fault),
  .replay(replay), .mem_go(mem_go), .fwd_valid(fwd_valid),
  .stall(stall), .blk_flag(blk_flag), .dcache_blocked(dcache_blocked)
);

// File: tb/test_stld_fwd_unit.sv
module test_stld_fwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8, AW = 16, DW = 64, SEQW = 8, LQW = 3, SIW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, ld_uncached = 0, ld_at_head = 0, ld_at_commit = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [3:0] ld_size = '0;
  logic [SEQW-1:0] ld_seq = '0, st_done_seq = '0;
  logic [LQW-1:0] ld_lq_idx = '0;
  logic [SIW-1:0] ld_sq_idx = '0, wb_ptr = '0;
  logic [D*AW-1:0] sq_addr;
  logic [D*4-1:0] sq_size;
  logic [D*DW-1:0] sq_data;
  logic [D-1:0] sq_done;
  logic [D*SEQW-1:0] sq_seq;
  logic dcache_blocked = 0, st_done_valid = 0, blk_clear = 0;
  logic fwd_valid, replay, fault, mem_go, stall, blk_flag;
  logic [DW-1:0] fwd_data;
  logic [SEQW-1:0] stall_st_seq, blk_seq;
  logic [LQW-1:0] stall_ld_idx;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stld_fwd_unit i_stld_fwd_unit (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] sq, input logic [2:0] wb, input logic [15:0] a,
                      input logic [3:0] sz, input logic [7:0] sq_n, input logic [2:0] lq);
    @(negedge clk);
    ld_sq_idx = sq; wb_ptr = wb; ld_addr = a; ld_size = sz;
    ld_seq = sq_n; ld_lq_idx = lq; ld_valid = 1'b1;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    ld_valid = 1'b0; ld_uncached = 1'b0; st_done_valid = 1'b0; blk_clear = 1'b0;
    #1;
  endtask

  task automatic set_entry(input int i, input logic [15:0] a, input logic [3:0] s,
                           input logic [63:0] d, input logic dn, input logic [7:0] q);
    sq_addr[i*AW +: AW] = a; sq_size[i*4 +: 4] = s; sq_data[i*DW +: DW] = d;
    sq_done[i] = dn; sq_seq[i*SEQW +: SEQW] = q;
  endtask

  // {sq_idx, wb_ptr, addr, size, kind(0 mem,1 fwd,2 replay), data}
  localparam logic [91:0] VEC [14] = '{
    {3'd1, 3'd0, 16'h0100, 4'd4, 2'd1, 64'h44332211},
    {3'd1, 3'd0, 16'h0104, 4'd4, 2'd1, 64'h88776655},
    {3'd1, 3'd0, 16'h0106, 4'd2, 2'd1, 64'h8877},
    {3'd3, 3'd0, 16'h0100, 4'd4, 2'd1, 64'hAABBCCDD},
    {3'd3, 3'd0, 16'h0100, 4'd8, 2'd1, 64'h8877665544332211},
    {3'd5, 3'd0, 16'h0100, 4'd8, 2'd2, 64'h0},
    {3'd4, 3'd0, 16'h0300, 4'd1, 2'd0, 64'h0},
    {3'd4, 3'd4, 16'h0100, 4'd4, 2'd0, 64'h0},
    {3'd1, 3'd6, 16'h0201, 4'd1, 2'd1, 64'hF0},
    {3'd1, 3'd0, 16'h0200, 4'd4, 2'd0, 64'h0},
    {3'd2, 3'd0, 16'h0200, 4'd2, 2'd1, 64'hBBAA},
    {3'd0, 3'd6, 16'h0200, 4'd4, 2'd2, 64'h0},
    {3'd1, 3'd1, 16'h0100, 4'd4, 2'd0, 64'h0},
    {3'd6, 3'd5, 16'h0400, 4'd2, 2'd1, 64'hBEEF}
  };

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_entry(0, 16'h0100, 4'd8, 64'h8877665544332211, 1'b0, 8'd10);
    set_entry(1, 16'h0200, 4'd4, 64'hDDCCBBAA, 1'b0, 8'd11);
    set_entry(2, 16'h0100, 4'd4, 64'hAABBCCDD, 1'b1, 8'd12);
    set_entry(3, 16'h0300, 4'd0, 64'h12345678, 1'b0, 8'd13);
    set_entry(4, 16'h0104, 4'd4, 64'h44443333, 1'b0, 8'd14);
    set_entry(5, 16'h0400, 4'd2, 64'hBEEF, 1'b0, 8'd15);
    set_entry(6, 16'h0500, 4'd8, 64'h0123456789ABCDEF, 1'b0, 8'd16);
    set_entry(7, 16'h01FE, 4'd4, 64'hCAFEF00D, 1'b0, 8'd17);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 fwd_valid", 64'(fwd_valid), 0);
    chk("R11 stall", 64'(stall), 0);
    chk("R11 blk_flag", 64'(blk_flag), 0);
    chk("R11 mem_go", 64'(mem_go | replay | fault), 0);
    rst_n = 1'b1;

    // Table: R1 R2 R3 R4 R5 R9
    for (int v = 0; v < 14; v++) begin
      load(VEC[v][91:89], VEC[v][88:86], VEC[v][85:70], VEC[v][69:66], 8'd100, 3'd0);
      chk($sformatf("R4 replay vec%0d", v), 64'(replay), 64'(VEC[v][65:64] == 2'd2));
      chk($sformatf("R9 mem_go vec%0d", v), 64'(mem_go), 64'(VEC[v][65:64] == 2'd0));
      idle();
      chk($sformatf("R3 fwd_valid vec%0d", v), 64'(fwd_valid), 64'(VEC[v][65:64] == 2'd1));
      if (VEC[v][65:64] == 2'd1)
        chk($sformatf("R3 R1 R5 fwd_data vec%0d", v), fwd_data, VEC[v][63:0]);
    end

    // R12 idle: inputs would forward but ld_valid low
    @(negedge clk);
    rst_n = 1'b0; #1; rst_n = 1'b1;
    ld_sq_idx = 3'd1; wb_ptr = 3'd0; ld_addr = 16'h0100; ld_size = 4'd4; ld_valid = 1'b0;
    #1;
    chk("R12 quiet outputs", 64'(replay | mem_go | fault), 0);
    @(negedge clk); #1;
    chk("R12 no forward", 64'(fwd_valid), 0);

    // R6 stall recording
    load(3'd5, 3'd0, 16'h0100, 4'd8, 8'd50, 3'd3);
    idle();
    chk("R6 stall set", 64'(stall), 1);
    chk("R6 stall store seq", 64'(stall_st_seq), 14);
    chk("R6 stall load idx", 64'(stall_ld_idx), 3);
    load(3'd5, 3'd0, 16'h0100, 4'd8, 8'd60, 3'd5);
    idle();
    chk("R6 younger ignored", 64'(stall_ld_idx), 3);
    load(3'd0, 3'd6, 16'h0200, 4'd4, 8'd40, 3'd1);
    idle();
    chk("R6 older replaces idx", 64'(stall_ld_idx), 1);
    chk("R6 older replaces seq", 64'(stall_st_seq), 17);
    // R7 completion
    @(negedge clk); st_done_valid = 1'b1; st_done_seq = 8'd14;
    idle();
    chk("R7 other store keeps stall", 64'(stall), 1);
    @(negedge clk); st_done_valid = 1'b1; st_done_seq = 8'd17;
    idle();
    chk("R7 matching store clears", 64'(stall), 0);

    // R8 uncacheable
    @(negedge clk); ld_uncached = 1'b1; ld_at_head = 1'b1; ld_at_commit = 1'b0;
    load(3'd1, 3'd0, 16'h0100, 4'd4, 8'd70, 3'd2);
    chk("R8 fault", 64'(fault), 1);
    chk("R8 replay", 64'(replay), 1);
    chk("R8 mem_go", 64'(mem_go), 0);
    idle();
    chk("R8 no forward", 64'(fwd_valid), 0);
    @(negedge clk); ld_uncached = 1'b1; ld_at_head = 1'b0; ld_at_commit = 1'b1;
    load(3'd5, 3'd0, 16'h0100, 4'd8, 8'd70, 3'd2);
    chk("R8 fault not head", 64'(fault), 1);
    idle();
    chk("R8 stall untouched", 64'(stall), 0);
    @(negedge clk); ld_uncached = 1'b1; ld_at_head = 1'b1; ld_at_commit = 1'b1;
    load(3'd1, 3'd0, 16'h0100, 4'd4, 8'd70, 3'd2);
    chk("R8 eligible no fault", 64'(fault), 0);
    idle();
    chk("R8 eligible forwards", fwd_data, 64'h44332211);

    // R10 blocked cache
    @(negedge clk); dcache_blocked = 1'b1;
    load(3'd1, 3'd0, 16'h0100, 4'd4, 8'd25, 3'd0);
    idle();
    chk("R10 forward not recorded", 64'(blk_flag), 0);
    load(3'd2, 3'd2, 16'h0100, 4'd4, 8'd30, 3'd0);
    idle();
    chk("R10 blk set", 64'(blk_flag), 1);
    chk("R10 blk seq", 64'(blk_seq), 30);
    load(3'd2, 3'd2, 16'h0100, 4'd4, 8'd35, 3'd0);
    idle();
    chk("R10 younger kept out", 64'(blk_seq), 30);
    load(3'd2, 3'd2, 16'h0100, 4'd4, 8'd20, 3'd0);
    idle();
    chk("R10 older replaces", 64'(blk_seq), 20);
    @(negedge clk); dcache_blocked = 1'b0; blk_clear = 1'b1;
    idle();
    chk("R10 clear", 64'(blk_flag), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule